// File: doc/BRIEF.md
# Mode-Shared Link Interrupt Unit

This block collects event pulses from the transceiver core of an infrared serial link and turns them into a single interrupt request. It holds two status banks. The slow bank serves the asynchronous character mode and the fast bank serves the framed modes. Each bank has a sticky source register, a mask register and a write-one-to-clear register. The bit positions are shared between the banks, but two of them name different events depending on the mode: bit 9 is a receive timeout in slow mode and an abort detection in the fast modes, and bit 8 is a framing error in slow mode and a CRC error in the fast modes. Bits 15, 11 and 7 mean frame-receive-end, buffer-area overflow and frame-transmit-end in both banks.

A control register holds the transfer-mode field and one mask bit per bank. Only the bank that matches the current transfer mode takes in events, and only that bank can drive the interrupt. The interrupt output is a registered OR over the unmasked, set source bits of that bank, gated by the bank's control mask bit. Software reads the source register, writes the same value to the clear register, and so acknowledges the events.

Top module: `lnk_irq_unit`

## Requirements
- R1: After reset both source registers read 0x0000, both mask registers read 0x8B80 (all implemented bits masked), the control register reads 0x0111 and irq_o is 0.
- R2: An event pulse on evt[4], evt[3], evt[2], evt[1] or evt[0] sets source bit 15, 11, 9, 8 or 7 in the active bank on the next clock edge. Once set, the bit stays set.
- R3: The active bank is chosen by control bits [15:14]: 00 selects the slow bank, 10 and 11 select the fast bank, and 01 selects neither. Events aimed at a bank that is not active leave its source register unchanged.
- R4: Writing to a clear register (slow at address 3, fast at address 6) resets every source bit whose data bit is one and leaves the other source bits alone. A clear register reads 0x0000.
- R5: If an event pulse and a clear write hit the same source bit in the same cycle, the bit ends up set.
- R6: Mask registers (slow at address 2, fast at address 5) store only bits 15, 11, 9, 8 and 7, and the other bits read 0. Writes to the source registers (slow at address 1, fast at address 4) and to address 7 have no effect, and address 7 reads 0.
- R7: irq_o is high in the cycle after the active bank has a source bit that is set while its mask bit is clear, provided that bank's control mask bit is 0. Otherwise irq_o is low.
- R8: The control register (address 0) stores only bits 15, 14, 8, 4 and 0, and the other bits read 0. Bit 0 gates the slow bank and bit 4 gates the fast bank, and a one means the bank is masked. Bit 8 is stored but has no effect on irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| evt | input | 5 | Event pulses: [4] rx end, [3] overflow, [2] timeout/abort, [1] framing/CRC error, [0] tx end |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an event pulse and a clear write landing on the same bit in the same cycle, in the bank that is currently active. Random stimulus alone seldom lines up the pulse, the clear address, the data bit and the mode. A directed sequence therefore forces this collision in both banks. Random traffic also keeps switching the mode field, including the reserved value 01, so that events arrive at banks that are not active. The bench then checks that a bank which was inactive while its sources were set cannot raise irq_o after the mode moves away from it.

// File: rtl/lnk_irq_pkg.sv
package lnk_irq_pkg;
   localparam int NSRC = 5;
   localparam int REG_W = 16;
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_S_SRC = 3'd1;
   localparam logic [2:0] A_S_MSK = 3'd2;
   localparam logic [2:0] A_S_CLR = 3'd3;
   localparam logic [2:0] A_F_SRC = 3'd4;
   localparam logic [2:0] A_F_MSK = 3'd5;
   localparam logic [2:0] A_F_CLR = 3'd6;
   localparam logic [REG_W-1:0] CTRL_IMPL = 16'hC111;
   localparam logic [REG_W-1:0] CTRL_RST  = 16'h0111;

   function automatic int bitpos(int i);
      case (i)
         4: return 15;
         3: return 11;
         2: return 9;
         1: return 8;
         default: return 7;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] spread(logic [NSRC-1:0] v);
      logic [REG_W-1:0] r;
      r = '0;
      for (int i = 0; i < NSRC; i++) r[bitpos(i)] = v[i];
      return r;
   endfunction

   function automatic logic [NSRC-1:0] squeeze(logic [REG_W-1:0] d);
      logic [NSRC-1:0] r;
      for (int i = 0; i < NSRC; i++) r[i] = d[bitpos(i)];
      return r;
   endfunction
endpackage

// File: rtl/lnk_irq_bank.sv
module lnk_irq_bank #(
   parameter int NBIT = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic [NBIT-1:0] ev,
   input  logic            msk_we,
   input  logic            clr_we,
   input  logic [NBIT-1:0] wbits,
   output logic [NBIT-1:0] src,
   output logic [NBIT-1:0] msk,
   output logic            pend
);
   initial begin
      assert (NBIT >= 1) else $error("bank needs at least one source");
   end

   logic [NBIT-1:0] ev_act;
   assign ev_act = active ? ev : '0;

   for (genvar i = 0; i < NBIT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src[i] <= 1'b0;
            msk[i] <= 1'b1;
         end else begin
            if (ev_act[i])                 src[i] <= 1'b1;
            else if (clr_we && wbits[i])   src[i] <= 1'b0;
            if (msk_we)                    msk[i] <= wbits[i];
         end
      end

      // R2: an accepted event is visible on the next edge
      assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
         ev_act[i] |=> src[i]);
      // R4: a clear without a colliding event empties the bit
      assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wbits[i] && !ev_act[i]) |=> !src[i]);
      // R5: a collision keeps the bit set
      assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wbits[i] && ev_act[i]) |=> src[i]);
   end

   // R3: an inactive bank holds its sources unless it is cleared
   assert_idle_bank_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clr_we) |=> $stable(src));

   assign pend = |(src & ~msk);
endmodule

// File: rtl/lnk_irq_gate.sv
module lnk_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_slow,
   input  logic pend_fast,
   input  logic sel_slow,
   input  logic sel_fast,
   input  logic gate_slow,
   input  logic gate_fast,
   output logic irq_q
);
   logic req;
   assign req = (sel_slow & pend_slow & ~gate_slow) |
                (sel_fast & pend_fast & ~gate_fast);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= req;
   end

   // R7: without a pending source in either bank no request follows
   assert_quiet_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_slow && !pend_fast) |=> !irq_q);
   // R8: both banks gated off means no request follows
   assert_gated_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_slow && gate_fast) |=> !irq_q);
endmodule

// File: rtl/lnk_irq_unit.sv
module lnk_irq_unit
   import lnk_irq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NSRC-1:0]   evt,
   output logic              irq_o
);
   initial begin
      assert (DATA_W == REG_W) else $error("register width must be 16");
      assert (ADDR_W == 3) else $error("address width must be 3");
   end

   logic [REG_W-1:0] ctrl_q;
   logic             sel_slow, sel_fast;
   logic [NSRC-1:0]  wbits;
   logic [NSRC-1:0]  s_src, s_msk, f_src, f_msk;
   logic             s_pend, f_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ctrl_q <= CTRL_RST;
      else if (wr_en && addr == A_CTRL)  ctrl_q <= wdata & CTRL_IMPL;
   end

   assign sel_slow = (ctrl_q[15:14] == 2'b00);
   assign sel_fast = ctrl_q[15];
   assign wbits    = squeeze(wdata);

   lnk_irq_bank #(.NBIT(NSRC)) i_slow (
      .clk(clk), .rst_n(rst_n), .active(sel_slow), .ev(evt),
      .msk_we(wr_en && addr == A_S_MSK), .clr_we(wr_en && addr == A_S_CLR),
      .wbits(wbits), .src(s_src), .msk(s_msk), .pend(s_pend));

   lnk_irq_bank #(.NBIT(NSRC)) i_fast (
      .clk(clk), .rst_n(rst_n), .active(sel_fast), .ev(evt),
      .msk_we(wr_en && addr == A_F_MSK), .clr_we(wr_en && addr == A_F_CLR),
      .wbits(wbits), .src(f_src), .msk(f_msk), .pend(f_pend));

   lnk_irq_gate i_gate (
      .clk(clk), .rst_n(rst_n), .pend_slow(s_pend), .pend_fast(f_pend),
      .sel_slow(sel_slow), .sel_fast(sel_fast),
      .gate_slow(ctrl_q[0]), .gate_fast(ctrl_q[4]), .irq_q(irq_o));

   always_comb begin
      case (addr)
         A_CTRL:  rdata = ctrl_q;
         A_S_SRC: rdata = spread(s_src);
         A_S_MSK: rdata = spread(s_msk);
         A_F_SRC: rdata = spread(f_src);
         A_F_MSK: rdata = spread(f_msk);
         default: rdata = '0;
      endcase
   end

   // R3: the reserved mode value never yields a request
   assert_reserved_mode_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[15:14] == 2'b01) |=> !irq_o);
   // R7: a request needs a source that was set one cycle earlier
   assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past((|s_src) || (|f_src)));
endmodule

// File: tb/test_lnk_irq_unit.sv
module test_lnk_irq_unit;
   import lnk_irq_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [4:0]  evt = '0;
   logic        irq_o;

   int vectors = 0, fails = 0;
   bit done = 0;

   logic [15:0] m_ctrl;
   logic [4:0]  m_src [2];
   logic [4:0]  m_msk [2];
   logic        m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   lnk_irq_unit i_lnk_irq_unit (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt(evt), .irq_o(irq_o));

   function automatic logic [15:0] exp_read(logic [2:0] a);
      case (a)
         3'd0: return m_ctrl;
         3'd1: return spread(m_src[0]);
         3'd2: return spread(m_msk[0]);
         3'd4: return spread(m_src[1]);
         3'd5: return spread(m_msk[1]);
         default: return 16'h0;
      endcase
   endfunction

   function automatic int bank_of(logic [15:0] c);
      if (c[15:14] == 2'b00) return 0;
      if (c[15]) return 1;
      return -1;
   endfunction

   function automatic logic exp_irq();
      int b = bank_of(m_ctrl);
      if (b < 0) return 1'b0;
      return (|(m_src[b] & ~m_msk[b])) && !m_ctrl[b == 0 ? 0 : 4];
   endfunction

   task automatic model_edge(logic w, logic [2:0] a, logic [15:0] d, logic [4:0] e);
      int b = bank_of(m_ctrl);
      logic [4:0] wb = squeeze(d);
      m_irq = exp_irq();
      for (int k = 0; k < 2; k++) begin
         if (w && a == (k == 0 ? 3'd3 : 3'd6)) m_src[k] = m_src[k] & ~wb;
         if (b == k) m_src[k] = m_src[k] | e;
         if (w && a == (k == 0 ? 3'd2 : 3'd5)) m_msk[k] = wb;
      end
      if (w && a == 3'd0) m_ctrl = d & 16'hC111;
   endtask

   task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic look(string tag, logic [2:0] a);
      wr_en = 0; evt = '0; addr = a;
      #1;
      cmp(tag, rdata, exp_read(a));
      cmp({tag, " irq R7"}, {15'h0, irq_o}, {15'h0, m_irq});
   endtask

   task automatic step(logic w, logic [2:0] a, logic [15:0] d, logic [4:0] e);
      wr_en = w; addr = a; wdata = d; evt = e;
      @(posedge clk);
      model_edge(w, a, d, e);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      m_ctrl = 16'h0111; m_src[0] = 0; m_src[1] = 0;
      m_msk[0] = 5'h1F; m_msk[1] = 5'h1F; m_irq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values against constants
      addr = 3'd0; #1 cmp("R1 ctrl", rdata, 16'h0111);
      addr = 3'd2; #1 cmp("R1 slow mask", rdata, 16'h8B80);
      addr = 3'd5; #1 cmp("R1 fast mask", rdata, 16'h8B80);
      addr = 3'd1; #1 cmp("R1 slow src", rdata, 16'h0000);
      cmp("R1 irq", {15'h0, irq_o}, 16'h0);
      // R2 every event position, slow mode
      step(1, 3'd0, 16'h0000, 5'h00);
      step(1, 3'd2, 16'h0000, 5'h00);
      step(0, 3'd7, 16'hFFFF, 5'h15);
      addr = 3'd1; #1 cmp("R2 slow bits 15/9/7", rdata, 16'h8280);
      @(negedge clk);
      cmp("R7 irq after slow event", {15'h0, irq_o}, 16'h1);
      // R3 fast bank untouched in slow mode
      addr = 3'd4; #1 cmp("R3 fast idle", rdata, 16'h0000);
      // R6 source write ignored
      step(1, 3'd1, 16'h0000, 5'h00);
      look("R6 src write ignored", 3'd1);
      // R5 collision in slow bank
      step(1, 3'd3, 16'hFFFF, 5'h01);
      addr = 3'd1; #1 cmp("R5 slow event wins", rdata, 16'h0080);
      // R4 partial clear then full
      step(1, 3'd3, 16'h0080, 5'h00);
      look("R4 slow cleared", 3'd1);
      look("R4 clear reads zero", 3'd3);
      // R8 gate and bit 8 no effect
      step(1, 3'd0, 16'h0101, 5'h02);
      step(0, 3'd0, 16'h0, 5'h00);
      look("R8 gated slow", 3'd0);
      step(1, 3'd0, 16'hFFFF, 5'h00);
      look("R8 ctrl implemented bits", 3'd0);
      // R3 fast collision and reserved mode
      step(1, 3'd0, 16'h8100, 5'h00);
      step(1, 3'd5, 16'h0000, 5'h00);
      step(1, 3'd6, 16'hFFFF, 5'h08);
      addr = 3'd4; #1 cmp("R5 fast event wins", rdata, 16'h0800);
      step(1, 3'd0, 16'h4000, 5'h1F);
      step(0, 3'd0, 16'h0, 5'h1F);
      look("R3 reserved ignores slow", 3'd1);
      look("R3 reserved ignores fast", 3'd4);
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] ra = 3'($urandom_range(0, 7));
         logic [15:0] rd = 16'($urandom);
         logic [4:0] re = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0;
         if (ra == 3'd0 && $urandom_range(0, 1) == 1) rd[4] = 1'b0;
         if ($urandom_range(0, 2) == 0) rd[0] = 1'b0;
         step($urandom_range(0, 1) == 1, ra, rd, re);
         look("R2 random", 3'($urandom_range(0, 7)));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule